// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of an asynchronous parallel NOR flash device. A requester hands it an operation code, a target address and a data word. The block turns that request into the bus cycles the flash needs: a fixed pair of unlock writes, one or more command writes and, for operations that run inside the device, a loop of status reads. The loop ends when status bit 7 shows that the operation has finished, or when the timeout status bits show that it has failed. At the end the block pulses done or err for one cycle. For identifier reads it also holds the code it read.

The width of the flash data bus is a parameter and may be 8, 16 or 32 bits. Fixed command offsets are given in word units. On a byte-wide bus they are shifted left by one bit, so that the physical address matches the width. Each bus access has three parts: one setup cycle, a chip-enable and strobe pulse that lasts a parameterised number of cycles, and one hold cycle. The address and write data are held constant through all three parts.

Top module: `nor_cmd_seq`

## Requirements
- R1: Every command sequence opens with two unlock writes: 0xAA to fixed offset 0x5555, then 0x55 to fixed offset 0xAAAA. Fixed offsets are shifted left by one bit when DATA_W is 8.
- R2: Op code 0 (program) writes 0xA0 to offset 0x5555 after the unlocks, then writes req_data to req_addr. It then polls req_addr and completes when bit 7 read back equals bit 7 of req_data.
- R3: Op code 1 (sector erase) writes AA, 55, 0x80, AA, 55 to the unlock offsets, then writes 0x30 to req_addr. It then polls req_addr and completes when bit 7 reads as 1.
- R4: Op code 2 (chip erase) uses the same five opening writes, then writes 0x10 to offset 0x5555 and polls address 0. A poll that reads bit 3 set while bit 7 is clear ends the operation with err, and no reset writes follow.
- R5: When a poll is incomplete and bit 5 is set, the block reads the same address exactly once more. If that read is complete it signals done. Otherwise it writes AA, 55, 0xF0 and then signals err.
- R6: Op codes 3 and 4 (identifier) write AA, 55, 0x90, then read offset 0 (code 3) or offset 1 (code 4). They then exit with AA, 55, 0xF0 and signal done, and id_out holds the value read.
- R7: Op code 5 (reset) writes AA, 55, 0xF0 and signals done without any read.
- R8: In each access, fl_ce_n and exactly one of fl_we_n or fl_oe_n are low together for exactly STROBE_CYC cycles. fl_addr and fl_dq_out are stable while fl_ce_n is low. fl_dq_oe is high only for writes.
- R9: req_ack is high only while the block is idle and req_valid carries a known op code. The block becomes busy in the next cycle. A request made while busy is not acknowledged and has no effect on the bus.
- R10: Every accepted request ends with exactly one one-cycle pulse of either done or err, never both, and busy is low in that cycle.
- R11: Op codes 6 and 7 are never acknowledged and start no bus access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Operation code (0 program, 1 sector erase, 2 chip erase, 3 maker id, 4 device id, 5 reset) |
| req_addr | input | ADDR_W | Target address in bus words |
| req_data | input | DATA_W | Word to program |
| req_ack | output | 1 | Request accepted this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse, operation succeeded |
| err | output | 1 | One-cycle pulse, operation failed |
| id_out | output | DATA_W | Last identifier read |
| fl_addr | output | ADDR_W | Flash address |
| fl_dq_out | output | DATA_W | Flash write data |
| fl_dq_oe | output | 1 | Drive enable for write data |
| fl_dq_in | input | DATA_W | Flash read data |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
The assertions check the bus protocol on every cycle: the strobes are never low together, chip enable goes low only with a strobe, the address and data hold while enabled, the strobe width is exact, the data bus is not driven during reads, and done and err are single, exclusive pulses with busy clear. Whether the right command bytes reach the right offsets, and whether each status pattern leads to the right outcome, only the bench's scenarios can show. These cover rechecks after a timeout bit, the chip-erase bit-3 abort, identifier values and requests made while busy. The bench predicts each access and compares it as it happens.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [2:0] {
        OP_PROG       = 3'd0,
        OP_SECT_ERASE = 3'd1,
        OP_CHIP_ERASE = 3'd2,
        OP_ID_MFR     = 3'd3,
        OP_ID_DEV     = 3'd4,
        OP_RESET      = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        AS_UNLK_A,
        AS_UNLK_B,
        AS_TARGET,
        AS_ZERO,
        AS_IDOFF
    } asel_e;

    typedef enum logic [1:0] {
        BP_IDLE,
        BP_SETUP,
        BP_STRB,
        BP_HOLD
    } bphase_e;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_CMD,
        CS_POLL,
        CS_RECHK,
        CS_IDRD,
        CS_EXIT
    } cstate_e;

    typedef struct packed {
        asel_e      asel;
        logic [7:0] code;
        logic       put_data;
        logic       last;
    } step_t;

    localparam logic [31:0] UNLK_A_OFS = 32'h5555;
    localparam logic [31:0] UNLK_B_OFS = 32'hAAAA;

    localparam logic [7:0] K_UNLK_A  = 8'hAA;
    localparam logic [7:0] K_UNLK_B  = 8'h55;
    localparam logic [7:0] K_PROG    = 8'hA0;
    localparam logic [7:0] K_ESETUP  = 8'h80;
    localparam logic [7:0] K_SECT    = 8'h30;
    localparam logic [7:0] K_CHIP    = 8'h10;
    localparam logic [7:0] K_AUTOSEL = 8'h90;
    localparam logic [7:0] K_EXIT    = 8'hF0;

    function automatic int unsigned ofs_shift(int unsigned dw);
        return (dw == 8) ? 1 : 0;
    endfunction

    function automatic logic op_known(logic [2:0] c);
        return c <= 3'd5;
    endfunction

    function automatic step_t mk(asel_e a, logic [7:0] c, logic pd, logic l);
        step_t s;
        s.asel     = a;
        s.code     = c;
        s.put_data = pd;
        s.last     = l;
        return s;
    endfunction

    // Write step k of the command phase for a given operation.
    function automatic step_t cmd_step(op_e op, logic [2:0] k);
        step_t s;
        case (k)
            3'd0: s = mk(AS_UNLK_A, K_UNLK_A, 1'b0, 1'b0);
            3'd1: s = mk(AS_UNLK_B, K_UNLK_B, 1'b0, 1'b0);
            3'd2: begin
                case (op)
                    OP_PROG:                   s = mk(AS_UNLK_A, K_PROG,    1'b0, 1'b0);
                    OP_SECT_ERASE,
                    OP_CHIP_ERASE:             s = mk(AS_UNLK_A, K_ESETUP,  1'b0, 1'b0);
                    OP_ID_MFR, OP_ID_DEV:      s = mk(AS_UNLK_A, K_AUTOSEL, 1'b0, 1'b1);
                    default:                   s = mk(AS_UNLK_A, K_EXIT,    1'b0, 1'b1);
                endcase
            end
            3'd3: begin
                if (op == OP_PROG) s = mk(AS_TARGET, 8'h00, 1'b1, 1'b1);
                else               s = mk(AS_UNLK_A, K_UNLK_A, 1'b0, 1'b0);
            end
            3'd4: s = mk(AS_UNLK_B, K_UNLK_B, 1'b0, 1'b0);
            3'd5: begin
                if (op == OP_SECT_ERASE) s = mk(AS_TARGET, K_SECT, 1'b0, 1'b1);
                else                     s = mk(AS_UNLK_A, K_CHIP, 1'b0, 1'b1);
            end
            default: s = mk(AS_UNLK_A, K_EXIT, 1'b0, 1'b1);
        endcase
        return s;
    endfunction

    // Write step k of the return-to-read sequence.
    function automatic step_t exit_step(logic [2:0] k);
        step_t s;
        case (k)
            3'd0:    s = mk(AS_UNLK_A, K_UNLK_A, 1'b0, 1'b0);
            3'd1:    s = mk(AS_UNLK_B, K_UNLK_B, 1'b0, 1'b0);
            default: s = mk(AS_UNLK_A, K_EXIT,   1'b0, 1'b1);
        endcase
        return s;
    endfunction

endpackage

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W     = 22,
    parameter int DATA_W     = 16,
    parameter int STROBE_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              go_read,
    input  logic [ADDR_W-1:0] go_addr,
    input  logic [DATA_W-1:0] go_data,
    output logic              idle,
    output logic              fin,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_dq_out,
    output logic              fl_dq_oe,
    input  logic [DATA_W-1:0] fl_dq_in,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n
);
    localparam int CW = $clog2(STROBE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(STROBE_CYC - 1);

    bphase_e       ph;
    logic [CW-1:0] cnt;
    logic          rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= BP_IDLE;
            cnt       <= '0;
            rd_q      <= 1'b0;
            fl_addr   <= '0;
            fl_dq_out <= '0;
            rd_data   <= '0;
        end else begin
            case (ph)
                BP_IDLE: begin
                    if (go) begin
                        ph        <= BP_SETUP;
                        rd_q      <= go_read;
                        fl_addr   <= go_addr;
                        fl_dq_out <= go_read ? '0 : go_data;
                    end
                end
                BP_SETUP: begin
                    ph  <= BP_STRB;
                    cnt <= '0;
                end
                BP_STRB: begin
                    if (cnt == LAST) begin
                        ph <= BP_HOLD;
                        if (rd_q) rd_data <= fl_dq_in;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ph <= BP_IDLE;
            endcase
        end
    end

    assign idle     = (ph == BP_IDLE);
    assign fin      = (ph == BP_HOLD);
    assign fl_ce_n  = (ph != BP_STRB);
    assign fl_we_n  = !((ph == BP_STRB) && !rd_q);
    assign fl_oe_n  = !((ph == BP_STRB) && rd_q);
    assign fl_dq_oe = (ph != BP_IDLE) && !rd_q;

endmodule

// File: rtl/nor_status_eval.sv
module nor_status_eval #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] rd,
    input  logic              is_prog,
    input  logic              exp_bit7,
    output logic              complete,
    output logic              tmo,
    output logic              erase_tmo
);
    always_comb begin
        complete  = is_prog ? (rd[7] == exp_bit7) : rd[7];
        tmo       = rd[5];
        erase_tmo = rd[3];
    end
endmodule

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ack,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] id_out,
    output logic              bus_go,
    output logic              bus_read,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    input  logic              bus_idle,
    input  logic              bus_fin,
    input  logic [DATA_W-1:0] bus_rd,
    output logic              is_prog,
    output logic              exp_bit7,
    input  logic              st_complete,
    input  logic              st_tmo,
    input  logic              st_erase_tmo
);
    localparam int unsigned SH = ofs_shift(DATA_W);
    localparam logic [ADDR_W-1:0] ADDR_UA = ADDR_W'(UNLK_A_OFS << SH);
    localparam logic [ADDR_W-1:0] ADDR_UB = ADDR_W'(UNLK_B_OFS << SH);
    localparam logic [ADDR_W-1:0] ADDR_ID1 = ADDR_W'(32'd1 << SH);

    cstate_e           st;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [2:0]        k;
    logic              pend;
    logic              fail_q;
    step_t             cur;
    logic [ADDR_W-1:0] id_addr;

    always_comb begin
        cur = (st == CS_EXIT) ? exit_step(k) : cmd_step(op_q, k);
    end

    assign id_addr  = (op_q == OP_ID_DEV) ? ADDR_ID1 : '0;
    assign req_ack  = req_valid && (st == CS_IDLE) && op_known(req_op);
    assign busy     = (st != CS_IDLE);
    assign bus_read = (st == CS_POLL) || (st == CS_RECHK) || (st == CS_IDRD);
    assign bus_go   = busy && !pend && bus_idle;
    assign is_prog  = (op_q == OP_PROG);
    assign exp_bit7 = data_q[7];

    always_comb begin
        bus_data = cur.put_data ? data_q : DATA_W'(cur.code);
        if (st == CS_IDRD) begin
            bus_addr = id_addr;
        end else if (st == CS_POLL || st == CS_RECHK) begin
            bus_addr = (op_q == OP_CHIP_ERASE) ? '0 : addr_q;
        end else begin
            case (cur.asel)
                AS_UNLK_A: bus_addr = ADDR_UA;
                AS_UNLK_B: bus_addr = ADDR_UB;
                AS_TARGET: bus_addr = addr_q;
                AS_IDOFF:  bus_addr = id_addr;
                default:   bus_addr = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= CS_IDLE;
            op_q   <= OP_PROG;
            addr_q <= '0;
            data_q <= '0;
            k      <= '0;
            pend   <= 1'b0;
            fail_q <= 1'b0;
            done   <= 1'b0;
            err    <= 1'b0;
            id_out <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (bus_go)       pend <= 1'b1;
            else if (bus_fin) pend <= 1'b0;
            case (st)
                CS_IDLE: begin
                    if (req_ack) begin
                        op_q   <= op_e'(req_op);
                        addr_q <= req_addr;
                        data_q <= req_data;
                        k      <= '0;
                        fail_q <= 1'b0;
                        st     <= CS_CMD;
                    end
                end
                CS_CMD: begin
                    if (bus_fin) begin
                        if (cur.last) begin
                            k <= '0;
                            case (op_q)
                                OP_PROG, OP_SECT_ERASE, OP_CHIP_ERASE: st <= CS_POLL;
                                OP_ID_MFR, OP_ID_DEV:                  st <= CS_IDRD;
                                default: begin
                                    st   <= CS_IDLE;
                                    done <= 1'b1;
                                end
                            endcase
                        end else begin
                            k <= k + 3'd1;
                        end
                    end
                end
                CS_POLL: begin
                    if (bus_fin) begin
                        if (st_complete) begin
                            st   <= CS_IDLE;
                            done <= 1'b1;
                        end else if (op_q == OP_CHIP_ERASE && st_erase_tmo) begin
                            st  <= CS_IDLE;
                            err <= 1'b1;
                        end else if (st_tmo) begin
                            st <= CS_RECHK;
                        end
                    end
                end
                CS_RECHK: begin
                    if (bus_fin) begin
                        if (st_complete) begin
                            st   <= CS_IDLE;
                            done <= 1'b1;
                        end else begin
                            fail_q <= 1'b1;
                            k      <= '0;
                            st     <= CS_EXIT;
                        end
                    end
                end
                CS_IDRD: begin
                    if (bus_fin) begin
                        id_out <= bus_rd;
                        k      <= '0;
                        st     <= CS_EXIT;
                    end
                end
                default: begin
                    if (bus_fin) begin
                        if (cur.last) begin
                            st   <= CS_IDLE;
                            err  <= fail_q;
                            done <= !fail_q;
                        end else begin
                            k <= k + 3'd1;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W     = 22,
    parameter int DATA_W     = 16,
    parameter int STROBE_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ack,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] id_out,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_dq_out,
    output logic              fl_dq_oe,
    input  logic [DATA_W-1:0] fl_dq_in,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n
);
    logic              bus_go, bus_read, bus_idle, bus_fin;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_data, bus_rd;
    logic              is_prog, exp_bit7;
    logic              st_complete, st_tmo, st_erase_tmo;

    nor_seq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .req_ack(req_ack), .busy(busy), .done(done), .err(err), .id_out(id_out),
        .bus_go(bus_go), .bus_read(bus_read), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_idle(bus_idle), .bus_fin(bus_fin), .bus_rd(bus_rd),
        .is_prog(is_prog), .exp_bit7(exp_bit7),
        .st_complete(st_complete), .st_tmo(st_tmo), .st_erase_tmo(st_erase_tmo)
    );

    nor_status_eval #(.DATA_W(DATA_W)) u_eval (
        .rd(bus_rd), .is_prog(is_prog), .exp_bit7(exp_bit7),
        .complete(st_complete), .tmo(st_tmo), .erase_tmo(st_erase_tmo)
    );

    nor_bus_cycle #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STROBE_CYC(STROBE_CYC)) u_bus (
        .clk(clk), .rst(rst),
        .go(bus_go), .go_read(bus_read), .go_addr(bus_addr), .go_data(bus_data),
        .idle(bus_idle), .fin(bus_fin), .rd_data(bus_rd),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
        .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
    parameter int ADDR_W     = 22,
    parameter int DATA_W     = 16,
    parameter int STROBE_CYC = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ack,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [DATA_W-1:0] fl_dq_out,
    input logic              fl_dq_oe,
    input logic              fl_ce_n,
    input logic              fl_we_n,
    input logic              fl_oe_n
);
    logic [15:0] lowcnt;

    always_ff @(posedge clk) begin
        if (rst)                       lowcnt <= '0;
        else if (!fl_we_n || !fl_oe_n) lowcnt <= lowcnt + 16'd1;
        else                           lowcnt <= '0;
    end

    a_r8_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(!fl_we_n && !fl_oe_n));
    a_r8_ce_with_strobe: assert property (@(posedge clk) disable iff (rst)
        (!fl_we_n || !fl_oe_n) |-> !fl_ce_n);
    a_r8_ce_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        !fl_ce_n |-> (!fl_we_n || !fl_oe_n));
    a_r8_bus_hold: assert property (@(posedge clk) disable iff (rst)
        (!fl_ce_n && $past(!fl_ce_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));
    a_r8_no_drive_read: assert property (@(posedge clk) disable iff (rst)
        !fl_oe_n |-> !fl_dq_oe);
    a_r8_strobe_width: assert property (@(posedge clk) disable iff (rst)
        (fl_we_n && fl_oe_n && lowcnt != 16'd0) |-> (lowcnt == 16'(STROBE_CYC)));
    a_r9_ack_when_idle: assert property (@(posedge clk) disable iff (rst)
        req_ack |-> !busy);
    a_r9_ack_starts: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> busy);
    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done && err));
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (done || err) |=> !(done || err));
    a_r10_idle_at_end: assert property (@(posedge clk) disable iff (rst)
        (done || err) |-> !busy);

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STROBE_CYC(STROBE_CYC)
) u_chk (
    .clk(clk), .rst(rst), .req_ack(req_ack), .busy(busy), .done(done), .err(err),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
);

// File: tb/sim_nor_cmd_seq.sv
module sim_nor_cmd_seq;
    localparam int AW = 22;
    localparam int DW = 16;
    localparam int SC = 3;
    localparam int SH = (DW == 8) ? 1 : 0;
    localparam logic [AW-1:0] UA = AW'(32'h5555 << SH);
    localparam logic [AW-1:0] UB = AW'(32'hAAAA << SH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          req_ack, busy, done, err;
    logic [DW-1:0] id_out;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_dq_out;
    logic          fl_dq_oe;
    logic [DW-1:0] fl_dq_in = '0;
    logic          fl_ce_n, fl_we_n, fl_oe_n;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit            rd;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        string         tag;
    } xact_t;

    xact_t         exp_q[$];
    logic [DW-1:0] resp_q[$];

    always #10 clk = ~clk;

    nor_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .STROBE_CYC(SC)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_ack(req_ack), .busy(busy),
        .done(done), .err(err), .id_out(id_out), .fl_addr(fl_addr),
        .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
        .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_w(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        xact_t x;
        x.rd = 1'b0; x.a = a; x.d = d; x.tag = tag;
        exp_q.push_back(x);
    endtask

    task automatic push_r(input logic [AW-1:0] a, input logic [DW-1:0] resp, input string tag);
        xact_t x;
        x.rd = 1'b1; x.a = a; x.d = '0; x.tag = tag;
        exp_q.push_back(x);
        resp_q.push_back(resp);
    endtask

    task automatic unlk();
        push_w(UA, DW'(8'hAA), "R1 first unlock");
        push_w(UB, DW'(8'h55), "R1 second unlock");
    endtask

    task automatic exit_seq(input string tag);
        unlk();
        push_w(UA, DW'(8'hF0), tag);
    endtask

    // Bus monitor: every cycle, compares each access as it starts and the strobe widths.
    bit pwe = 1'b1, poe = 1'b1;
    int lowc = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (pwe && !fl_we_n) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected write", {fl_addr, fl_dq_out}, 64'd0);
                end else begin
                    xact_t x;
                    x = exp_q.pop_front();
                    chk(!x.rd && fl_addr == x.a && fl_dq_out == x.d && fl_dq_oe,
                        x.tag, {fl_addr, fl_dq_out}, {x.a, x.d});
                end
            end
            if (poe && !fl_oe_n) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected read", {42'd0, fl_addr}, 64'd0);
                end else begin
                    xact_t x;
                    x = exp_q.pop_front();
                    chk(x.rd && fl_addr == x.a && !fl_dq_oe, x.tag, {42'd0, fl_addr}, {42'd0, x.a});
                end
                fl_dq_in <= (resp_q.size() != 0) ? resp_q.pop_front() : '0;
            end
            if (!fl_we_n || !fl_oe_n) begin
                lowc++;
            end else if (lowc != 0) begin
                chk(lowc == SC, "R8 strobe width", 64'(lowc), 64'(SC));
                lowc = 0;
            end
            if (done && err) chk(1'b0, "R10 done and err together", 64'd1, 64'd0);
        end
        pwe = fl_we_n;
        poe = fl_oe_n;
    end

    task automatic run_op(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit exp_err, input string req);
        bit got;
        bit sawd;
        bit sawe;
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        #1 got = req_ack;
        chk(got, "R9 ack when idle", 64'(got), 64'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        sawd = 1'b0; sawe = 1'b0; n = 0;
        while (!sawd && !sawe && n < 5000) begin
            if (done) sawd = 1'b1;
            if (err)  sawe = 1'b1;
            if (!sawd && !sawe) begin
                @(negedge clk);
                n++;
            end
        end
        chk((sawd || sawe) && (sawe == exp_err) && !busy, req, {62'd0, sawe, sawd},
            {62'd0, exp_err, !exp_err});
        @(negedge clk);
        chk(!done && !err, "R10 one-cycle pulse", {62'd0, err, done}, 64'd0);
        chk(exp_q.size() == 0, {req, " all accesses issued"}, 64'(exp_q.size()), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe, "R8 reset bus idle",
            {60'd0, fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe}, 64'he);
        chk(!busy && !done && !err && !req_ack, "R10 reset flags",
            {60'd0, busy, done, err, req_ack}, 64'd0);
        rst = 1'b0;

        // R2 program, success on second poll (data bit7 = 0)
        unlk();
        push_w(UA, DW'(8'hA0), "R2 program setup");
        push_w(22'h012340, 16'h1234, "R2 program data");
        push_r(22'h012340, 16'h0080, "R2 poll target");
        push_r(22'h012340, 16'h1234, "R2 poll target");
        run_op(3'd0, 22'h012340, 16'h1234, 1'b0, "R2 program done");

        // R5 timeout bit, recheck complete (data bit7 = 1)
        unlk();
        push_w(UA, DW'(8'hA0), "R2 program setup");
        push_w(22'h000100, 16'h00FF, "R2 program data");
        push_r(22'h000100, 16'h0020, "R5 poll");
        push_r(22'h000100, 16'h0080, "R5 recheck");
        run_op(3'd0, 22'h000100, 16'h00FF, 1'b0, "R5 recheck recovers");

        // R5 timeout bit, recheck incomplete -> reset sequence and err
        unlk();
        push_w(UA, DW'(8'hA0), "R2 program setup");
        push_w(22'h000200, 16'h00A5, "R2 program data");
        push_r(22'h000200, 16'h0020, "R5 poll");
        push_r(22'h000200, 16'h0020, "R5 recheck");
        exit_seq("R5 reset command");
        run_op(3'd0, 22'h000200, 16'h00A5, 1'b1, "R5 program fail");

        // R3 sector erase
        unlk();
        push_w(UA, DW'(8'h80), "R3 erase setup");
        unlk();
        push_w(22'h020000, DW'(8'h30), "R3 sector command");
        push_r(22'h020000, 16'h0000, "R3 poll sector");
        push_r(22'h020000, 16'h0044, "R3 poll sector");
        push_r(22'h020000, 16'h0080, "R3 poll sector");
        run_op(3'd1, 22'h020000, 16'hFFFF, 1'b0, "R3 sector erase done");

        // R4 chip erase success
        unlk();
        push_w(UA, DW'(8'h80), "R4 erase setup");
        unlk();
        push_w(UA, DW'(8'h10), "R4 chip command");
        push_r('0, 16'h0000, "R4 poll zero");
        push_r('0, 16'h0080, "R4 poll zero");
        run_op(3'd2, 22'h033333, 16'h0000, 1'b0, "R4 chip erase done");

        // R4 chip erase bit3 abort, no reset writes
        unlk();
        push_w(UA, DW'(8'h80), "R4 erase setup");
        unlk();
        push_w(UA, DW'(8'h10), "R4 chip command");
        push_r('0, 16'h0008, "R4 poll zero");
        run_op(3'd2, 22'h000000, 16'h0000, 1'b1, "R4 chip erase bit3 error");
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0 && fl_ce_n, "R4 no writes after bit3 abort", 64'(exp_q.size()), 64'd0);

        // R5 on chip erase: timeout twice -> reset and err
        unlk();
        push_w(UA, DW'(8'h80), "R4 erase setup");
        unlk();
        push_w(UA, DW'(8'h10), "R4 chip command");
        push_r('0, 16'h0020, "R5 poll zero");
        push_r('0, 16'h0020, "R5 recheck zero");
        exit_seq("R5 reset command");
        run_op(3'd2, 22'h000000, 16'h0000, 1'b1, "R5 chip erase fail");

        // R6 maker id
        unlk();
        push_w(UA, DW'(8'h90), "R6 autoselect");
        push_r('0, 16'h00C2, "R6 read offset 0");
        exit_seq("R6 exit command");
        run_op(3'd3, 22'h001234, 16'h0000, 1'b0, "R6 maker id done");
        chk(id_out == 16'h00C2, "R6 maker id value", 64'(id_out), 64'h00C2);

        // R6 device id
        unlk();
        push_w(UA, DW'(8'h90), "R6 autoselect");
        push_r(AW'(32'd1 << SH), 16'h227E, "R6 read offset 1");
        exit_seq("R6 exit command");
        run_op(3'd4, 22'h000000, 16'h0000, 1'b0, "R6 device id done");
        chk(id_out == 16'h227E, "R6 device id value", 64'(id_out), 64'h227E);

        // R7 reset
        exit_seq("R7 reset command");
        run_op(3'd5, 22'h000000, 16'h0000, 1'b0, "R7 reset done");

        // R9 request while busy has no effect
        unlk();
        push_w(UA, DW'(8'hA0), "R2 program setup");
        push_w(22'h000400, 16'h0011, "R2 program data");
        for (int i = 0; i < 5; i++) push_r(22'h000400, 16'h0080, "R9 poll");
        push_r(22'h000400, 16'h0011, "R9 poll");
        fork
            run_op(3'd0, 22'h000400, 16'h0011, 1'b0, "R9 program with intrusion");
            begin
                bit a;
                repeat (12) @(negedge clk);
                req_valid = 1'b1; req_op = 3'd5; req_addr = '0;
                #1 a = req_ack;
                chk(!a && busy, "R9 no ack while busy", {62'd0, a, busy}, 64'd1);
                repeat (4) @(negedge clk);
                req_valid = 1'b0;
            end
        join
        repeat (20) @(negedge clk);
        chk(!busy && exp_q.size() == 0, "R9 ignored request left no work", 64'(busy), 64'd0);

        // R11 unknown op codes
        for (int c = 6; c < 8; c++) begin
            bit a;
            @(negedge clk);
            req_valid = 1'b1; req_op = 3'(c);
            #1 a = req_ack;
            chk(!a, "R11 unknown op not acked", 64'(a), 64'd0);
            @(negedge clk);
            req_valid = 1'b0;
            repeat (10) @(negedge clk);
            chk(!busy && fl_ce_n, "R11 unknown op starts nothing", 64'(busy), 64'd0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule